// File: doc/BRIEF.md
# Card Status Word Collector

This block sits on the card side of a flash memory card controller. It keeps the 32-bit status word that goes back to the host in native-mode responses. The command and data engines report faults and events to it as single-cycle pulses. The card's state machine supplies its present state and a few status levels.

Each bit of the word has its own lifetime:

- Most error and event bits stay set until the response logic reads the word.
- The command-integrity bits last through one further valid command and are dropped at the next one.
- The state-following fields are never stored; they are copied straight from their inputs.

A second output repacks the same information into the 16-bit layout that the serial-peripheral mode response uses. In that layout a low byte carries the basic flags and a high byte carries the extended flags.

The response builder samples `status_o` in the cycle it asserts `rd_i`. Bits that clear on read drop out in the following cycle. The command decoder pulses `cmd_ok_i` once for every command it accepts as valid.

Top module: `card_status_reg`

## Requirements
- R1: While reset is low, and after it is released until an event arrives, every stored bit reads 0; status_o then shows only the fields driven by cur_state_i, locked_i, ecc_off_i and rdy_data_i.
- R2: A pulse on evt_i[k], for k in {31..26, 24, 21..15, 13, 5} or k in {23, 22}, makes status_o[k] read 1 from the next cycle. The bit stays at 1 until its own clear rule applies.
- R3: The read-clear bits are 31..26, 24, 21..15, 13 and 5. In a cycle with rd_i high, status_o still shows them. In the next cycle they read 0.
- R4: If evt_i[k] for a read-clear bit k is high in the same cycle as rd_i, status_o[k] reads 1 in the next cycle.
- R5: Bits 23 (command CRC error) and 22 (illegal command) ignore rd_i. Once set, such a bit survives the first cmd_ok_i pulse after it was set and reads 0 after the second. An event on the bit that coincides with cmd_ok_i sets it again and restarts this count.
- R6: status_o[25] equals locked_i, status_o[14] equals ecc_off_i, status_o[12:9] equals cur_state_i and status_o[8] equals rdy_data_i, all in the same cycle with no storage.
- R7: Pulses on evt_i bits 25, 14, 12..6 and 4..0 change nothing. status_o[7:6] and status_o[4:0] always read 0.
- R8: spi_o[7:0] is laid out as follows:
  - bit 0 is 1 when cur_state_i equals 0 (idle);
  - bit 1 = status bit 13;
  - bit 2 = bit 22;
  - bit 3 = bit 23;
  - bit 4 = bit 28;
  - bit 5 = bit 30;
  - bit 6 = bit 29 OR bit 31;
  - bit 7 is always 0.
- R9: spi_o[15:8] is laid out as follows:
  - bit 8 = status bit 25;
  - bit 9 = bit 15 OR bit 24;
  - bit 10 = bit 19;
  - bit 11 = bit 20;
  - bit 12 = bit 21;
  - bit 13 = bit 26;
  - bit 14 = bit 27;
  - bit 15 = bit 31 OR bit 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 32 | Event pulses, one per native status bit position |
| cur_state_i | input | 4 | Present card state code |
| rdy_data_i | input | 1 | Card ready to accept data |
| locked_i | input | 1 | Card is locked |
| ecc_off_i | input | 1 | Internal ECC disabled |
| rd_i | input | 1 | Response builder reads the status word this cycle |
| cmd_ok_i | input | 1 | A valid command was accepted this cycle |
| status_o | output | 32 | Native-mode status word |
| spi_o | output | 16 | Serial-mode view: flag byte low, extended byte high |

## Verification
The hardest case to reach is the delayed clear of the command-integrity bits. It only shows when an event, reads and two separate valid-command pulses arrive in a set order, and when an event lands on the same edge as a command pulse. The bench drives these orderings as directed sequences first. It then runs a long pseudo-random stretch in which events, reads and command pulses overlap freely, so that read-clear bits and delayed-clear bits are set and cleared on the same edges. A step-by-step model of the clear rules predicts the word at every cycle.

// File: rtl/cstat_pkg.sv
package cstat_pkg;

    localparam int WORD_W  = 32;
    localparam int SPI_W   = 16;

    // bits that drop after the response builder reads the word
    localparam logic [WORD_W-1:0] RDCLR_MASK = 32'hFD3F_A020;
    // bits that drop one valid command after they were reported
    localparam logic [WORD_W-1:0] LAGCLR_MASK = 32'h00C0_0000;

    localparam int POS_LOCKED  = 25;
    localparam int POS_ECC_OFF = 14;
    localparam int POS_STATE   = 9;
    localparam int POS_RDY     = 8;

    typedef struct packed {
        logic [WORD_W-1:0] flag;
        logic [WORD_W-1:0] seen;
    } lag_regs_t;

    // flags feeding the serial-mode repack
    typedef struct packed {
        logic out_rng;
        logic addr_err;
        logic blk_len;
        logic erase_seq;
        logic erase_prm;
        logic wp_viol;
        logic locked;
        logic lock_fail;
        logic crc_err;
        logic illegal;
        logic ecc_fail;
        logic cc_err;
        logic gen_err;
        logic csd_ovw;
        logic erase_skip;
        logic erase_rst;
    } spi_src_t;

endpackage

// File: rtl/cstat_rdclr_bank.sv
module cstat_rdclr_bank #(
    parameter int          W    = 32,
    parameter logic [W-1:0] MASK = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt_i,
    input  logic         rd_i,
    output logic [W-1:0] bits_o
);

    logic [W-1:0] bits_d, bits_q;

    // a pulse in the read cycle re-sets the bit, so it is never lost
    always_comb begin
        bits_d = (evt_i | (bits_q & {W{~rd_i}})) & MASK;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bits_q <= '0;
        else        bits_q <= bits_d;
    end

    assign bits_o = bits_q;

endmodule

// File: rtl/cstat_lag_bank.sv
module cstat_lag_bank
    import cstat_pkg::*;
#(
    parameter int          W    = 32,
    parameter logic [W-1:0] MASK = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt_i,
    input  logic         cmd_i,
    output logic [W-1:0] bits_o
);

    typedef struct packed {
        logic [W-1:0] flag;
        logic [W-1:0] seen;
    } regs_t;

    regs_t r_d, r_q;
    logic [W-1:0] cmd_v;

    always_comb begin
        cmd_v     = {W{cmd_i}};
        // a bit already carried through one command goes on the next
        r_d.flag  = (evt_i | (r_q.flag & ~(cmd_v & r_q.seen))) & MASK;
        // a fresh event restarts the count
        r_d.seen  = ~evt_i & r_d.flag & (r_q.seen | cmd_v) & MASK;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign bits_o = r_q.flag;

endmodule

// File: rtl/cstat_spi_view.sv
module cstat_spi_view
    import cstat_pkg::*;
#(
    parameter int          STATE_W   = 4,
    parameter logic [STATE_W-1:0] IDLE_CODE = '0
) (
    input  spi_src_t            src_i,
    input  logic [STATE_W-1:0]  state_i,
    output logic [SPI_W-1:0]    spi_o
);

    logic [7:0] flag_byte;
    logic [7:0] ext_byte;

    always_comb begin
        flag_byte    = '0;
        flag_byte[0] = (state_i == IDLE_CODE);
        flag_byte[1] = src_i.erase_rst;
        flag_byte[2] = src_i.illegal;
        flag_byte[3] = src_i.crc_err;
        flag_byte[4] = src_i.erase_seq;
        flag_byte[5] = src_i.addr_err;
        flag_byte[6] = src_i.blk_len | src_i.out_rng;
        flag_byte[7] = 1'b0;

        ext_byte[0]  = src_i.locked;
        ext_byte[1]  = src_i.erase_skip | src_i.lock_fail;
        ext_byte[2]  = src_i.gen_err;
        ext_byte[3]  = src_i.cc_err;
        ext_byte[4]  = src_i.ecc_fail;
        ext_byte[5]  = src_i.wp_viol;
        ext_byte[6]  = src_i.erase_prm;
        ext_byte[7]  = src_i.out_rng | src_i.csd_ovw;
    end

    assign spi_o = {ext_byte, flag_byte};

endmodule

// File: rtl/card_status_reg.sv
module card_status_reg
    import cstat_pkg::*;
#(
    parameter int          STATE_W   = 4,
    parameter logic [STATE_W-1:0] IDLE_CODE = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [31:0]        evt_i,
    input  logic [STATE_W-1:0] cur_state_i,
    input  logic               rdy_data_i,
    input  logic               locked_i,
    input  logic               ecc_off_i,
    input  logic               rd_i,
    input  logic               cmd_ok_i,
    output logic [31:0]        status_o,
    output logic [SPI_W-1:0]   spi_o
);

    logic [WORD_W-1:0] rdclr_bits;
    logic [WORD_W-1:0] lag_bits;
    logic [WORD_W-1:0] track_bits;
    logic [WORD_W-1:0] word;
    spi_src_t          spi_src;

    cstat_rdclr_bank #(.W(WORD_W), .MASK(RDCLR_MASK)) u_rdclr (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_i  (evt_i),
        .rd_i   (rd_i),
        .bits_o (rdclr_bits)
    );

    cstat_lag_bank #(.W(WORD_W), .MASK(LAGCLR_MASK)) u_lag (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_i  (evt_i),
        .cmd_i  (cmd_ok_i),
        .bits_o (lag_bits)
    );

    always_comb begin
        track_bits                              = '0;
        track_bits[POS_LOCKED]                  = locked_i;
        track_bits[POS_ECC_OFF]                 = ecc_off_i;
        track_bits[POS_STATE +: STATE_W]        = cur_state_i;
        track_bits[POS_RDY]                     = rdy_data_i;
        word = rdclr_bits | lag_bits | track_bits;
    end

    always_comb begin
        spi_src.out_rng    = word[31];
        spi_src.addr_err   = word[30];
        spi_src.blk_len    = word[29];
        spi_src.erase_seq  = word[28];
        spi_src.erase_prm  = word[27];
        spi_src.wp_viol    = word[26];
        spi_src.locked     = word[25];
        spi_src.lock_fail  = word[24];
        spi_src.crc_err    = word[23];
        spi_src.illegal    = word[22];
        spi_src.ecc_fail   = word[21];
        spi_src.cc_err     = word[20];
        spi_src.gen_err    = word[19];
        spi_src.csd_ovw    = word[16];
        spi_src.erase_skip = word[15];
        spi_src.erase_rst  = word[13];
    end

    cstat_spi_view #(.STATE_W(STATE_W), .IDLE_CODE(IDLE_CODE)) u_spi (
        .src_i   (spi_src),
        .state_i (cur_state_i),
        .spi_o   (spi_o)
    );

    assign status_o = word;

endmodule

// File: rtl/cstat_chk.sv
module cstat_chk
    import cstat_pkg::*;
#(
    parameter int STATE_W = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [31:0]        evt_i,
    input logic [STATE_W-1:0] cur_state_i,
    input logic               rd_i,
    input logic               cmd_ok_i,
    input logic               locked_i,
    input logic [31:0]        status_o,
    input logic [SPI_W-1:0]   spi_o
);

    localparam logic [31:0] STORE_MASK = RDCLR_MASK | LAGCLR_MASK;

    // R2
    evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_o & $past(evt_i & STORE_MASK)) == $past(evt_i & STORE_MASK)));

    // R3
    rd_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_i |=> ((status_o & RDCLR_MASK & ~$past(evt_i)) == '0));

    // R5
    lag_rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !cmd_ok_i && status_o[23]) |=> status_o[23]);

    // R7
    zero_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[7:6] == 2'b00) && (status_o[4:0] == 5'b00000));

    // R7
    no_spont_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt_i[31] && !status_o[31]) |=> !status_o[31]);

    // R6
    state_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[POS_STATE +: STATE_W] == cur_state_i) && (status_o[POS_LOCKED] == locked_i));

    // R8
    spi_bit7_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_o[7] == 1'b0);

    // R9
    spi_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_o[8] == status_o[25]);

endmodule

bind card_status_reg cstat_chk #(.STATE_W(STATE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_i       (evt_i),
    .cur_state_i (cur_state_i),
    .rd_i        (rd_i),
    .cmd_ok_i    (cmd_ok_i),
    .locked_i    (locked_i),
    .status_o    (status_o),
    .spi_o       (spi_o)
);

// File: tb/card_status_reg_test.sv
module card_status_reg_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] evt = '0;
    logic [3:0]  st = '0;
    logic        rdy = 1'b0, lock = 1'b0, ecc = 1'b0, rd = 1'b0, cmd = 1'b0;
    logic [31:0] status_o;
    logic [15:0] spi_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    localparam logic [31:0] RDCLR = 32'hFD3F_A020;

    // expectation model
    logic [31:0] m_rdclr = '0;
    logic        m_flag[2];
    logic        m_seen[2];

    logic [31:0] q_st[$];
    logic [15:0] q_sp[$];
    string       q_tag[$];

    always #10 clk = ~clk;   // 50 MHz

    card_status_reg uut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .cur_state_i(st),
        .rdy_data_i(rdy), .locked_i(lock), .ecc_off_i(ecc),
        .rd_i(rd), .cmd_ok_i(cmd), .status_o(status_o), .spi_o(spi_o)
    );

    function automatic logic [15:0] spi_of(input logic [31:0] n, input logic [3:0] s);
        logic [15:0] v;
        v     = '0;
        v[0]  = (s == 4'd0);
        v[1]  = n[13]; v[2] = n[22]; v[3] = n[23]; v[4] = n[28];
        v[5]  = n[30]; v[6] = n[29] | n[31]; v[7] = 1'b0;
        v[8]  = n[25]; v[9] = n[15] | n[24]; v[10] = n[19]; v[11] = n[20];
        v[12] = n[21]; v[13] = n[26]; v[14] = n[27]; v[15] = n[31] | n[16];
        return v;
    endfunction

    // driver: applies one cycle of stimulus and queues what the ports must show
    task automatic step(input logic [31:0] e, input logic r, input logic c,
                        input logic [3:0] s, input logic lk, input logic ec,
                        input logic rl, input string tag);
        logic [31:0] exp;
        @(negedge clk);
        evt = e; rd = r; cmd = c; st = s; lock = lk; ecc = ec; rdy = rl;
        #1;
        exp = m_rdclr;
        exp[23] = m_flag[1];
        exp[22] = m_flag[0];
        exp[25] = lk; exp[14] = ec; exp[12:9] = s; exp[8] = rl;
        q_st.push_back(exp);
        q_sp.push_back(spi_of(exp, s));
        q_tag.push_back(tag);
        if (rst_n) begin
            m_rdclr = (m_rdclr & ~(r ? RDCLR : 32'h0)) | (e & RDCLR);
            for (int b = 0; b < 2; b++) begin
                if (e[22 + b]) begin
                    m_flag[b] = 1'b1; m_seen[b] = 1'b0;
                end else if (c && m_flag[b]) begin
                    if (m_seen[b]) begin m_flag[b] = 1'b0; m_seen[b] = 1'b0; end
                    else m_seen[b] = 1'b1;
                end
            end
        end
    endtask

    task automatic idle(input string tag);
        step('0, 1'b0, 1'b0, 4'd4, 1'b0, 1'b0, 1'b0, tag);
    endtask

    // monitor: pops and compares
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (q_st.size() > 0) begin
                logic [31:0] es;
                logic [15:0] ep;
                string t;
                es = q_st.pop_front();
                ep = q_sp.pop_front();
                t  = q_tag.pop_front();
                checks++;
                if (status_o !== es) begin
                    fails++;
                    $display("FAIL %s status_o actual=%h expected=%h", t, status_o, es);
                end
                checks++;
                if (spi_o !== ep) begin
                    fails++;
                    $display("FAIL %s spi_o actual=%h expected=%h", t, spi_o, ep);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] x;
        m_flag[0] = 1'b0; m_flag[1] = 1'b0; m_seen[0] = 1'b0; m_seen[1] = 1'b0;
        // R1: under reset, events are not stored
        step(32'hFFFF_FFFF, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0, 1'b0, "R1");
        step('0, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0, 1'b0, "R1");
        @(negedge clk); rst_n = 1'b1;
        step('0, 1'b0, 1'b0, 4'd3, 1'b0, 1'b0, 1'b1, "R1");

        // R2 then R3: set, read returns value, then cleared
        step(32'h8000_0000, 1'b0, 1'b0, 4'd4, 1'b0, 1'b0, 1'b0, "R2");
        idle("R2");
        step('0, 1'b1, 1'b0, 4'd4, 1'b0, 1'b0, 1'b0, "R3");
        idle("R3");

        // R9/R8: every read-clear bit at once
        step(RDCLR, 1'b0, 1'b0, 4'd0, 1'b1, 1'b0, 1'b0, "R2");
        step('0, 1'b0, 1'b0, 4'd0, 1'b1, 1'b0, 1'b0, "R9");
        step('0, 1'b1, 1'b0, 4'd0, 1'b0, 1'b0, 1'b0, "R8");
        idle("R3");

        // R4: event coincident with read survives
        step(32'h4000_0000, 1'b0, 1'b0, 4'd4, 1'b0, 1'b0, 1'b0, "R4");
        step(32'h4000_0020, 1'b1, 1'b0, 4'd4, 1'b0, 1'b0, 1'b0, "R4");
        idle("R4");
        step('0, 1'b1, 1'b0, 4'd4, 1'b0, 1'b0, 1'b0, "R4");
        idle("R4");

        // R7: non-storable positions ignored
        step(32'h0200_5FDF, 1'b0, 1'b0, 4'd4, 1'b0, 1'b0, 1'b0, "R7");
        idle("R7");

        // R6: tracking fields follow inputs
        step('0, 1'b0, 1'b0, 4'd9, 1'b1, 1'b1, 1'b1, "R6");
        step('0, 1'b0, 1'b0, 4'd15, 1'b0, 1'b1, 1'b0, "R6");

        // R5: delayed clear across two commands, immune to reads
        step(32'h0080_0000, 1'b0, 1'b0, 4'd4, 1'b0, 1'b0, 1'b0, "R5");
        step('0, 1'b1, 1'b0, 4'd4, 1'b0, 1'b0, 1'b0, "R5");
        step('0, 1'b0, 1'b1, 4'd4, 1'b0, 1'b0, 1'b0, "R5");
        idle("R5");
        step('0, 1'b0, 1'b1, 4'd4, 1'b0, 1'b0, 1'b0, "R5");
        idle("R5");
        // R5: event on same edge as command restarts the count
        step(32'h0040_0000, 1'b0, 1'b0, 4'd4, 1'b0, 1'b0, 1'b0, "R5");
        step('0, 1'b0, 1'b1, 4'd4, 1'b0, 1'b0, 1'b0, "R5");
        step(32'h0040_0000, 1'b0, 1'b1, 4'd4, 1'b0, 1'b0, 1'b0, "R5");
        step('0, 1'b0, 1'b1, 4'd4, 1'b0, 1'b0, 1'b0, "R5");
        step('0, 1'b0, 1'b1, 4'd4, 1'b0, 1'b0, 1'b0, "R5");
        idle("R5");

        // R8: serial flag byte with idle state and mixed flags
        step(32'h30C0_2000, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0, 1'b0, "R8");
        step('0, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0, 1'b0, "R8");
        step('0, 1'b1, 1'b0, 4'd1, 1'b0, 1'b0, 1'b0, "R8");
        idle("R8");

        // mixed pseudo-random traffic
        x = 32'h1234_5678;
        for (int i = 0; i < 300; i++) begin
            logic [31:0] y;
            x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
            y = x ^ (x << 7);
            step(x & y & (y >> 3), x[0] & x[9], x[3], x[7:4], x[11], x[12], x[14],
                 "R2/R3/R4/R5/R9");
        end
        idle("R3");

        @(negedge clk);
        @(negedge clk);
        #5;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule